// File: doc/BRIEF.md
# Encoded-Interval Watchdog Timer

This block is a watchdog timer programmed through a single byte-wide configuration register. Its timeout is packed into seven bits: a five-bit multiplier and a two-bit resolution code. Together they give a timeout of `multiplier × 4^code` periods of an external 16 Hz tick, so the range runs from one sixteenth of a second to 1984 ticks.

Any bus access to the configuration register restarts the count from the full interval and clears the expiry flag, whether it is a write or a read. Software services the watchdog by touching that register periodically. If the count runs out, the block sets a sticky expiry flag. The top bit of the configuration register then chooses what happens next. With the bit clear, the block raises a single interrupt pulse. With the bit set, it raises a single system-reset request pulse, clears the configuration register and clears bit 6 of a companion calendar byte.

The bus is a plain byte register port with a combinational read path. The 16 Hz tick generator and the reset network are outside the block.

Top module: `enc_wdt`

## Requirements
- R1: After reset, the configuration register (address 0), the flag register (address 1) and the calendar byte (address 2) read 0x00, and `irq_o` and `sys_rst_req_o` are low. Address 3 always reads 0x00.
- R2: The configuration register holds the multiplier M in bits 6:2 and the code C in bits 1:0. With M nonzero, expiry occurs on the (M × 4^C)-th tick counted after the clock edge that performed the last access to the configuration register. Both outputs become visible in the cycle after that tick edge.
- R3: A multiplier of zero disables the watchdog for any code, and no tick then causes expiry. Writing 0x00 is one such case.
- R4: A write to the configuration register stores the byte, clears the expiry flag and restarts the count from the full interval encoded by the new value.
- R5: A read of the configuration register returns its value in the same cycle, clears the expiry flag and restarts the count from the full interval.
- R6: Expiry sets bit 7 of the flag register, which reads as {flag, 7'b0}. The flag stays set until the next configuration access. Bus writes to the flag register have no effect.
- R7: With bit 7 of the configuration register clear at expiry, `irq_o` is high for exactly one cycle, `sys_rst_req_o` stays low, and the counter stops until the next configuration access, so there is no repeat.
- R8: With bit 7 set at expiry, `sys_rst_req_o` is high for exactly one cycle and `irq_o` stays low. The configuration register becomes 0x00, bit 6 of the calendar byte is cleared and the calendar byte's other bits are kept.
- R9: A configuration access in the same cycle as the final tick takes priority: no expiry occurs and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse at each 1/16 s period |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address (0 config, 1 flag, 2 calendar) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid while a read is selected |
| irq_o | output | 1 | One-cycle interrupt pulse on expiry |
| sys_rst_req_o | output | 1 | One-cycle system-reset request on expiry |

## Verification
The bench builds the block with its default widths: a five-bit multiplier and a two-bit code. At these widths every interval fits in one short run, so the bench sweeps all 128 encodings with the steering bit clear. For each one it drives one tick per clock and checks that expiry lands on exactly the computed tick, fires once and sets the flag. Steering-set encodings at each code value reach the reset path and the calendar bit clear. Directed sequences cover mid-count restarts by a write and by a read, writes to the read-only flag register, and an access that coincides with the final tick.

// File: rtl/enc_wdt_pkg.sv
package enc_wdt_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CFG  = 2'd0,
        REG_FLAG = 2'd1,
        REG_CAL  = 2'd2,
        REG_NONE = 2'd3
    } reg_addr_e;

    localparam int DATA_W      = 8;
    localparam int STEER_BIT   = 7;
    localparam int CAL_CLR_BIT = 6;
endpackage

// File: rtl/enc_wdt_interval.sv
module enc_wdt_interval #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2,
    parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
    input  logic [MULT_W+RES_W-1:0] cfg_i,
    output logic [CNT_W-1:0]        interval_o
);
    localparam int NCODES = 1 << RES_W;

    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  code;
    logic [CNT_W-1:0]  scaled [NCODES];

    assign mult = cfg_i[MULT_W+RES_W-1:RES_W];
    assign code = cfg_i[RES_W-1:0];

    for (genvar c = 0; c < NCODES; c++) begin : g_scale
        assign scaled[c] = CNT_W'(mult) << (2 * c);
    end

    assign interval_o = scaled[code];
endmodule

// File: rtl/enc_wdt_countdown.sv
module enc_wdt_countdown #(
    parameter int CNT_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] interval_i,
    input  logic             tick_i,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } cd_state_t;

    cd_state_t st_d, st_q;
    logic      last_tick;

    always_comb begin
        st_d      = st_q;
        last_tick = st_q.armed && tick_i && (st_q.cnt == CNT_W'(1));
        expire_o  = last_tick && !load_i;
        if (load_i) begin
            st_d.cnt   = interval_i;
            st_d.armed = (interval_i != '0);
        end else if (st_q.armed && tick_i) begin
            if (last_tick) begin
                st_d.cnt   = '0;
                st_d.armed = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/enc_wdt.sv
module enc_wdt
    import enc_wdt_pkg::*;
#(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              sys_rst_req_o
);
    localparam int CFG_W = MULT_W + RES_W;
    localparam int CNT_W = MULT_W + 2 * ((1 << RES_W) - 1);

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] cal;
        logic              flag;
        logic              irq;
        logic              rst_req;
    } top_state_t;

    top_state_t        st_d, st_q;
    logic              cfg_access;
    logic              cfg_write;
    logic [CFG_W-1:0]  cfg_src;
    logic [CNT_W-1:0]  interval;
    logic              expire;

    assign cfg_access = bus_sel_i && (bus_addr_i == REG_CFG);
    assign cfg_write  = cfg_access && bus_wr_i;
    assign cfg_src    = cfg_write ? bus_wdata_i[CFG_W-1:0] : st_q.cfg[CFG_W-1:0];

    enc_wdt_interval #(
        .MULT_W (MULT_W),
        .RES_W  (RES_W),
        .CNT_W  (CNT_W)
    ) u_interval (
        .cfg_i      (cfg_src),
        .interval_o (interval)
    );

    enc_wdt_countdown #(
        .CNT_W (CNT_W)
    ) u_countdown (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (cfg_access),
        .interval_i (interval),
        .tick_i     (tick_i),
        .expire_o   (expire)
    );

    always_comb begin
        st_d         = st_q;
        st_d.irq     = 1'b0;
        st_d.rst_req = 1'b0;
        if (bus_sel_i && bus_wr_i) begin
            case (bus_addr_i)
                REG_CFG: st_d.cfg = bus_wdata_i;
                REG_CAL: st_d.cal = bus_wdata_i;
                default: ;
            endcase
        end
        if (cfg_access) begin
            st_d.flag = 1'b0;
        end else if (expire) begin
            st_d.flag = 1'b1;
            if (st_q.cfg[STEER_BIT]) begin
                st_d.cfg              = '0;
                st_d.cal[CAL_CLR_BIT] = 1'b0;
                st_d.rst_req          = 1'b1;
            end else begin
                st_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i && !bus_wr_i) begin
            case (bus_addr_i)
                REG_CFG:  bus_rdata_o = st_q.cfg;
                REG_FLAG: bus_rdata_o = {st_q.flag, {(DATA_W-1){1'b0}}};
                REG_CAL:  bus_rdata_o = st_q.cal;
                default:  bus_rdata_o = '0;
            endcase
        end
    end

    assign irq_o         = st_q.irq;
    assign sys_rst_req_o = st_q.rst_req;

    logic              mon_flag;
    logic [DATA_W-1:0] mon_cfg;
    logic [DATA_W-1:0] mon_cal;
    assign mon_flag = st_q.flag;
    assign mon_cfg  = st_q.cfg;
    assign mon_cal  = st_q.cal;
endmodule

// File: rtl/enc_wdt_chk.sv
module enc_wdt_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       sel_i,
    input logic [1:0] addr_i,
    input logic       irq_i,
    input logic       rst_req_i,
    input logic       flag_i,
    input logic [7:0] cfg_i,
    input logic [7:0] cal_i
);
    p_irq_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |=> !irq_i);

    p_rst_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_i |=> !rst_req_i);

    p_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(irq_i && rst_req_i));

    p_rst_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_i |-> (cfg_i == 8'h00) && !cal_i[6]);

    p_access_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && addr_i == 2'd0) |=> !flag_i);

    p_access_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && addr_i == 2'd0) |=> !(irq_i || rst_req_i));

    p_flag_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag_i) |-> (irq_i || rst_req_i));

    p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_i && !(sel_i && addr_i == 2'd0)) |=> flag_i);
endmodule

bind enc_wdt enc_wdt_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (bus_sel_i),
    .addr_i    (bus_addr_i),
    .irq_i     (irq_o),
    .rst_req_i (sys_rst_req_o),
    .flag_i    (mon_flag),
    .cfg_i     (mon_cfg),
    .cal_i     (mon_cal)
);

// File: tb/enc_wdt_tb_top.sv
`timescale 1ns/1ps
module enc_wdt_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;
    logic       rreq;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    enc_wdt dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .tick_i        (tick),
        .bus_sel_i     (sel),
        .bus_wr_i      (wr),
        .bus_addr_i    (addr),
        .bus_wdata_i   (wdata),
        .bus_rdata_o   (rdata),
        .irq_o         (irq),
        .sys_rst_req_o (rreq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic run_ticks(input int n, output int irq_first, output int irq_cnt,
                             output int rst_first, output int rst_cnt);
        irq_first = 0; irq_cnt = 0; rst_first = 0; rst_cnt = 0;
        @(negedge clk);
        tick = 1'b1;
        for (int k = 1; k <= n; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (irq) begin irq_cnt++; if (irq_first == 0) irq_first = k; end
            if (rreq) begin rst_cnt++; if (rst_first == 0) rst_first = k; end
        end
        tick = 1'b0;
    endtask

    function automatic int exp_ticks(input logic [7:0] v);
        return int'(v[6:2]) * (1 << (2 * int'(v[1:0])));
    endfunction

    initial begin : watchdog
        wait (cycles > 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [7:0] rd;
        int fi, ci, fr, cr, n;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk(irq == 1'b0 && rreq == 1'b0, "R1 outputs", {irq, rreq}, 0);
        for (int a = 0; a < 4; a++) begin
            bus_read(2'(a), rd);
            chk(rd == 8'h00, "R1 reset read", rd, 0);
        end

        // R2/R3/R6/R7 sweep of all encodings, steering clear
        for (int v = 0; v < 128; v++) begin
            n = exp_ticks(8'(v));
            bus_write(2'd0, 8'(v));
            bus_read(2'd1, rd);
            chk(rd == 8'h00, "R4 flag cleared by write", rd, 0);
            bus_write(2'd0, 8'(v));
            if (n == 0) begin
                run_ticks(8, fi, ci, fr, cr);
                chk(ci == 0 && cr == 0, "R3 disabled no expiry", ci + cr, 0);
            end else begin
                run_ticks(n + 4, fi, ci, fr, cr);
                chk(fi == n, "R2 expiry tick", fi, n);
                chk(ci == 1 && cr == 0, "R7 single irq no repeat", ci, 1);
                bus_read(2'd1, rd);
                chk(rd == 8'h80, "R6 flag set", rd, 8'h80);
            end
        end

        // R6 writes to flag register ignored
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, rd);
        chk(rd == 8'h80, "R6 write 0 ignored", rd, 8'h80);
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'hFF);
        bus_read(2'd1, rd);
        chk(rd == 8'h00, "R6 write FF ignored", rd, 0);

        // R4 mid-count write restart
        bus_write(2'd0, 8'h0C);
        run_ticks(2, fi, ci, fr, cr);
        chk(ci == 0, "R4 no early expiry", ci, 0);
        bus_write(2'd0, 8'h0C);
        run_ticks(6, fi, ci, fr, cr);
        chk(fi == 3, "R4 restart after write", fi, 3);

        // R5 mid-count read restart and flag clear
        bus_write(2'd0, 8'h0C);
        run_ticks(2, fi, ci, fr, cr);
        bus_read(2'd0, rd);
        chk(rd == 8'h0C, "R5 read value", rd, 8'h0C);
        run_ticks(6, fi, ci, fr, cr);
        chk(fi == 3, "R5 restart after read", fi, 3);
        bus_read(2'd0, rd);
        bus_read(2'd1, rd);
        chk(rd == 8'h00, "R5 read clears flag", rd, 0);

        // R9 access on the final tick
        bus_write(2'd0, 8'h0C);
        run_ticks(2, fi, ci, fr, cr);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 2'd0; wdata = 8'h0C; tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; tick = 1'b0;
        chk(irq == 1'b0, "R9 access beats final tick", irq, 0);
        run_ticks(6, fi, ci, fr, cr);
        chk(fi == 3, "R9 restart from full", fi, 3);

        // R8 reset steering at each code
        for (int c = 0; c < 4; c++) begin
            logic [7:0] v;
            v = 8'h80 | 8'h04 | 8'(c);
            bus_write(2'd2, 8'hC7);
            bus_write(2'd0, v);
            n = exp_ticks(v);
            run_ticks(n + 4, fi, ci, fr, cr);
            chk(fr == n, "R8 reset request tick", fr, n);
            chk(cr == 1 && ci == 0, "R8 single reset pulse", cr, 1);
            bus_read(2'd1, rd);
            chk(rd == 8'h80, "R8 flag set", rd, 8'h80);
            bus_read(2'd2, rd);
            chk(rd == 8'h87, "R8 calendar bit 6 cleared", rd, 8'h87);
            bus_read(2'd0, rd);
            chk(rd == 8'h00, "R8 config cleared", rd, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule